// File: doc/BRIEF.md
# Windowed Watchdog with Status Word

This block supervises software with a windowed watchdog. Each watchdog period is counted in base ticks, and its length is the base period times a divider picked by a 3-bit code. The first half of every period is a closed window and the second half is an open window. Software must refresh the watchdog in the open window. A refresh there starts a new period. A refresh in the closed window, or a period that runs out, produces a one-cycle reset request. The block also records why that request was made.

Configuration goes through one combined write port. The port carries a select bit and three data bits. With select low the data loads the watchdog code. With select high the data loads the cyclic-sense code, which is passed on to a neighbouring block. Every write and every status read answers one cycle later with the 4-bit status word. That answer clears the recorded reset cause.

The control is a four-state machine. OFF is held while the mode input is low. OFF goes to CLOSED when the mode input rises. CLOSED goes to OPEN once half the period's ticks have been counted. CLOSED goes to TRIP on a refresh (early refresh). OPEN goes back to CLOSED on a refresh, which starts a new period. OPEN goes to TRIP when the full period of ticks has been counted (expiry). TRIP lasts one cycle and then returns to CLOSED, or to OFF if the mode input is low. Every state goes to OFF when the mode input is low.

Top module: `win_watchdog`

## Requirements
- R1: After power-on reset the watchdog code and the cyclic-sense code are 000, both cause flags are clear, and no reset request is made. With the mode input low, the status word reads 0010.
- R2: The period equals BASE_TICKS times a divider. The watchdog code selects the divider: code 000 gives 1, and any other code c gives 2·c (so 111 gives 14).
- R3: Status bit 0 (window open) is 0 for the first half of the period's ticks and 1 for the second half.
- R4: If no refresh arrives, a reset request lasting exactly one cycle is made when the last tick of the period is counted. That request sets status bit 3 (timeout) and clears status bit 2 (error), and a new period then starts.
- R5: A refresh while the window is closed causes a one-cycle reset request in the next cycle, and sets both status bit 3 and status bit 2.
- R6: A refresh while the window is open makes no reset request and starts a new period, beginning with the closed window.
- R7: A write with select = 1 loads the cyclic-sense code output and leaves the watchdog code unchanged. A write with select = 0 loads the watchdog code.
- R8: While the mode input is low, no ticks are counted and no reset request is made. Status bit 1 (off) is 1 and bit 0 is 0. Writes to the watchdog code are ignored.
- R9: Every write and every status read makes the response valid for one cycle, in the cycle after the access. The response data is the status word as it stood during the access.
- R10: Any access clears status bits 3 and 2. Without an access they keep their value after the reset request until power-on reset. If a reset request is raised in the same cycle as an access, the request wins.
- R11: The period counter advances only on cycles where the base tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Base tick enable |
| win_mode | input | 1 | Windowed watchdog active |
| refresh | input | 1 | Watchdog refresh strobe |
| wr_en | input | 1 | Write strobe for the combined register |
| wr_sel | input | 1 | 0 selects the watchdog code, 1 selects the cyclic-sense code |
| wr_data | input | 3 | Code value being written |
| rd_en | input | 1 | Status read strobe |
| rsp_valid | output | 1 | Response valid, one cycle after an access |
| rsp_data | output | 4 | Status word captured during the access |
| status | output | 4 | Live status word: {timeout, error, off, window open} |
| wdg_rst | output | 1 | One-cycle reset request |
| cs_code | output | 3 | Cyclic-sense code for the neighbouring block |

## Verification
The bench builds the block with BASE_TICKS = 8. At that size the longest period is 112 cycles, so every one of the eight divider codes can be swept in full, together with its window split and expiry time. With divider code 000 every refresh offset in the period can be tried, from the first closed tick to the last open tick. This shows where early refresh ends and a valid restart begins. Ticks at half rate and held ticks show that timing follows the base tick.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    localparam int CODE_W = 3;
    localparam int STAT_W = 4;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CLOSED,
        ST_OPEN,
        ST_TRIP
    } wd_state_e;

    // Divider selected by the watchdog code: 1 for code zero, twice the code otherwise
    function automatic logic [3:0] div_of(input logic [CODE_W-1:0] code);
        return (code == '0) ? 4'd1 : {code, 1'b0};
    endfunction

endpackage

// File: rtl/wdw_cfg.sv
module wdw_cfg
    import wdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_mode,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] wd_code,
    output logic [CODE_W-1:0] cs_code
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_code <= '0;
            cs_code <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                cs_code <= wr_data;
            end else if (win_mode) begin
                wd_code <= wr_data;
            end
        end
    end

    AST_WD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel || !win_mode)) |=> $stable(wd_code)); // R8
    AST_CS_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> $stable(cs_code)); // R7

endmodule

// File: rtl/wdw_fsm.sv
module wdw_fsm
    import wdw_pkg::*;
#(
    parameter int BASE_TICKS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              win_mode,
    input  logic              refresh,
    input  logic [CODE_W-1:0] wd_code,
    output logic              win_open,
    output logic              wd_off,
    output logic              wdg_rst,
    output logic              trip_evt,
    output logic              trip_early
);

    localparam int MAX_DIV = 14;
    localparam int CNT_W   = $clog2(BASE_TICKS * MAX_DIV + 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] period_c, half_c, cnt_inc;

    always_comb begin
        period_c = CNT_W'(BASE_TICKS * int'(div_of(wd_code)));
        half_c   = period_c >> 1;
        cnt_inc  = cnt_q + CNT_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        trip_evt   = 1'b0;
        trip_early = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
                if (win_mode) begin
                    state_d = ST_CLOSED;
                end
            end
            ST_CLOSED: begin
                if (!win_mode) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (refresh) begin
                    state_d    = ST_TRIP;
                    cnt_d      = '0;
                    trip_evt   = 1'b1;
                    trip_early = 1'b1;
                end else if (tick) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc >= half_c) begin
                        state_d = ST_OPEN;
                    end
                end
            end
            ST_OPEN: begin
                if (!win_mode) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (refresh) begin
                    state_d = ST_CLOSED;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_inc >= period_c) begin
                        state_d  = ST_TRIP;
                        cnt_d    = '0;
                        trip_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            ST_TRIP: begin
                cnt_d   = '0;
                state_d = win_mode ? ST_CLOSED : ST_OFF;
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        win_open = (state_q == ST_OPEN);
        wd_off   = (state_q == ST_OFF);
        wdg_rst  = (state_q == ST_TRIP);
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst |=> !wdg_rst); // R4
    AST_EARLY_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open == 1'b0 && state_q == ST_CLOSED && win_mode && refresh) |=> wdg_rst); // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !win_mode |=> (wd_off && !wdg_rst && !win_open)); // R8
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOSED && win_mode && !tick && !refresh)
        |=> (state_q == ST_CLOSED && $stable(cnt_q))); // R11

endmodule

// File: rtl/wdw_status.sv
module wdw_status
    import wdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic              trip_evt,
    input  logic              trip_early,
    input  logic              wd_off,
    input  logic              win_open,
    output logic [STAT_W-1:0] status,
    output logic              rsp_valid,
    output logic [STAT_W-1:0] rsp_data
);

    logic to_q, err_q;

    always_comb begin
        status = {to_q, err_q, wd_off, win_open};
    end

    // A reset request recorded in the same cycle as an access is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_q  <= 1'b0;
            err_q <= 1'b0;
        end else if (trip_evt) begin
            to_q  <= 1'b1;
            err_q <= trip_early;
        end else if (access) begin
            to_q  <= 1'b0;
            err_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= access;
            if (access) begin
                rsp_data <= status;
            end
        end
    end

    AST_FLAG_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        trip_evt |=> to_q); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !trip_evt) |=> (!to_q && !err_q)); // R10
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && !trip_evt) |=> ($stable(to_q) && $stable(err_q))); // R10
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(access)) |-> 1'b0); // R9

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdw_pkg::*;
#(
    parameter int BASE_TICKS = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 win_mode,
    input  logic                 refresh,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [2:0]           wr_data,
    input  logic                 rd_en,
    output logic                 rsp_valid,
    output logic [3:0]           rsp_data,
    output logic [3:0]           status,
    output logic                 wdg_rst,
    output logic [2:0]           cs_code
);

    logic [CODE_W-1:0] wd_code;
    logic              win_open, wd_off, trip_evt, trip_early;
    logic              access;

    always_comb begin
        access = wr_en | rd_en;
    end

    wdw_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_mode (win_mode),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .wd_code  (wd_code),
        .cs_code  (cs_code)
    );

    wdw_fsm #(
        .BASE_TICKS (BASE_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .win_mode   (win_mode),
        .refresh    (refresh),
        .wd_code    (wd_code),
        .win_open   (win_open),
        .wd_off     (wd_off),
        .wdg_rst    (wdg_rst),
        .trip_evt   (trip_evt),
        .trip_early (trip_early)
    );

    wdw_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .access     (access),
        .trip_evt   (trip_evt),
        .trip_early (trip_early),
        .wd_off     (wd_off),
        .win_open   (win_open),
        .status     (status),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    AST_REQ_MARKS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst |-> status[3]); // R4

endmodule

// File: tb/win_watchdog_tb_top.sv
module win_watchdog_tb_top;

    localparam int BASE = 8;

    logic       clk = 1'b0;
    logic       rst_n, tick, win_mode, refresh, wr_en, wr_sel, rd_en;
    logic [2:0] wr_data;
    logic       rsp_valid, wdg_rst;
    logic [3:0] rsp_data, status;
    logic [2:0] cs_code;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  tick_alt = 0;

    always #5 clk = ~clk;

    win_watchdog #(.BASE_TICKS(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .win_mode(win_mode),
        .refresh(refresh), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .status(status), .wdg_rst(wdg_rst), .cs_code(cs_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_div(input int code);
        return (code == 0) ? 1 : 2 * code;
    endfunction

    task automatic access(input bit is_wr, input bit sel, input int data,
                          output logic [3:0] rsp, output logic vld);
        wr_en   = is_wr;
        rd_en   = !is_wr;
        wr_sel  = sel;
        wr_data = 3'(data);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        rsp   = rsp_data;
        vld   = rsp_valid;
    endtask

    task automatic measure(output int f_open, output int f_trip, output logic [3:0] trip_stat);
        win_mode = 1'b0;
        @(negedge clk);
        win_mode = 1'b1;
        tick     = tick_alt ? 1'b0 : 1'b1;
        f_open = -1;
        f_trip = -1;
        trip_stat = '0;
        for (int n = 0; n < 400 && f_trip < 0; n++) begin
            @(negedge clk);
            if (status[0] && f_open < 0) f_open = n;
            if (wdg_rst) begin
                f_trip = n;
                trip_stat = status;
            end
            tick = tick_alt ? 1'(n % 2) : 1'b1;
        end
        tick = 1'b1;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] r;
        logic       v;
        int         fo, ft, tr;
        logic [3:0] ts;
        bit         seen;

        rst_n = 1'b0; tick = 1'b1; win_mode = 1'b0; refresh = 1'b0;
        wr_en = 1'b0; wr_sel = 1'b0; rd_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", int'(status), 4'b0010);
        chk("R1 cs_code", int'(cs_code), 0);
        chk("R1 wdg_rst", int'(wdg_rst), 0);
        measure(fo, ft, ts);
        chk("R1 default period", ft, BASE);

        // R2 R3 R4: sweep every divider code
        for (int c = 0; c < 8; c++) begin
            win_mode = 1'b1;
            access(1'b1, 1'b0, c, r, v);
            measure(fo, ft, ts);
            chk($sformatf("R3 open start code %0d", c), fo, BASE * exp_div(c) / 2);
            chk($sformatf("R2 period code %0d", c), ft, BASE * exp_div(c));
            chk($sformatf("R4 flags code %0d", c), int'(ts[3:2]), 2'b10);
            @(negedge clk);
            chk("R4 one cycle", int'(wdg_rst), 0);
            repeat (5) @(negedge clk);
            chk("R10 flag kept", int'(status[3]), 1);
            access(1'b0, 1'b0, 0, r, v);
            chk("R9 read valid", int'(v), 1);
            chk("R9 read data", int'(r[3]), 1);
            chk("R10 read clears", int'(status[3:2]), 0);
            @(negedge clk);
            chk("R9 valid pulse", int'(rsp_valid), 0);
        end

        // R5 R6: every refresh offset with code 000
        win_mode = 1'b1;
        access(1'b1, 1'b0, 0, r, v);
        for (int off = 0; off < BASE; off++) begin
            access(1'b0, 1'b0, 0, r, v);
            win_mode = 1'b0;
            @(negedge clk);
            win_mode = 1'b1;
            @(negedge clk);
            repeat (off) @(negedge clk);
            refresh = 1'b1;
            @(negedge clk);
            refresh = 1'b0;
            if (off < BASE / 2) begin
                chk($sformatf("R5 early req off %0d", off), int'(wdg_rst), 1);
                chk($sformatf("R5 early flags off %0d", off), int'(status[3:2]), 2'b11);
            end else begin
                chk($sformatf("R6 no req off %0d", off), int'(wdg_rst), 0);
                chk($sformatf("R6 closed again off %0d", off), int'(status[0]), 0);
                tr = -1;
                for (int m = off + 2; m < off + 2 * BASE + 4 && tr < 0; m++) begin
                    @(negedge clk);
                    if (wdg_rst) tr = m;
                end
                chk($sformatf("R6 restart off %0d", off), tr, off + 1 + BASE);
            end
        end

        // R8: mode low ignores watchdog writes and stays quiet
        win_mode = 1'b1;
        access(1'b1, 1'b0, 2, r, v);
        access(1'b0, 1'b0, 0, r, v);
        win_mode = 1'b0;
        access(1'b1, 1'b0, 5, r, v);
        seen = 0;
        for (int k = 0; k < 3 * BASE * 14; k++) begin
            @(negedge clk);
            if (wdg_rst || status != 4'b0010) seen = 1;
        end
        chk("R8 quiet while off", int'(seen), 0);
        measure(fo, ft, ts);
        chk("R8 write ignored", ft, BASE * exp_div(2));

        // R7 R9 R10: cyclic-sense write returns status, clears flags
        win_mode = 1'b1;
        access(1'b1, 1'b1, 5, r, v);
        chk("R9 write valid", int'(v), 1);
        chk("R9 write data", int'(r), 4'b1000);
        chk("R10 write clears", int'(status[3]), 0);
        chk("R7 cs_code", int'(cs_code), 5);
        measure(fo, ft, ts);
        chk("R7 wd code kept", ft, BASE * exp_div(2));

        // R11: half-rate ticks and held ticks
        tick_alt = 1;
        measure(fo, ft, ts);
        tick_alt = 0;
        chk("R11 open half rate", fo, BASE * exp_div(2));
        chk("R11 period half rate", ft, 2 * BASE * exp_div(2));
        win_mode = 1'b0;
        @(negedge clk);
        win_mode = 1'b1;
        tick = 1'b0;
        seen = 0;
        for (int k = 0; k < 3 * BASE * 14; k++) begin
            @(negedge clk);
            if (wdg_rst || status[0]) seen = 1;
        end
        tick = 1'b1;
        chk("R11 held tick", int'(seen), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule